// File: doc/BRIEF.md
# Downward Trim Calibration Sequencer

This controller finds a new pair of resistor trim codes (an R0 code that sets where the reference curve peaks, and an R4 code that sets its level) for a curve segment whose peak lies below the temperature at which calibration starts. The die cannot be cooled on purpose. The sequencer therefore waits for the ambient temperature to fall, and uses the on-die heater only to warm back up. It gets the codes by driving DAC codes, pulsing named sample strobes for an external analog comparator, and reading that comparator's single result bit.

The R0 search compares two voltage differences. The first is the drop of the original curve between the start point and a point half a segment lower. The second is the same drop on the trial curve. The sequencer runs a most-significant-bit-first binary search over the R0 code, one trial per cool/heat cycle. The R4 search follows. The heater holds the die at a quarter segment below the start point by on/off control with a hysteresis band. In each R4 trial the original curve is sampled, then the new curve, and a direct comparison is requested. Once both codes are known, they are applied. The sequencer then re-arms itself when the sensor falls a full segment below its start point.

Top module: `dn_cal_sequencer`

## Requirements
- R1: After reset, r0Code, r4Code, lowR0 and lowR4 are zero, and heaterOn, done, cmpReq and all four strobes are low.
- R2: A start pulse in idle records the sensor code as the start point S0 and applies origR0/origR4 to r0Code/r4Code at that clock edge. smpV0a pulses for one cycle in the following cycle.
- R3: After the start-point sample, the sequencer waits with the heater off and the codes unchanged until sensCode + SPAN/2 <= S0. It then pulses smpV0b. If that level is never reached it stays waiting, with no strobes and no code change.
- R4: Each R0 trial applies the trial code (the first trial is 1 followed by zeros, i.e. 2^(CODE_W-1)) and then pulses smpV1a. The heater is then on until sensCode >= S0, at which point smpV1b pulses. In the next cycle cmpReq is high with cmpDiff = 1 (difference comparison).
- R5: Binary search: at each comparison, cmpBit = 1 means the trial code is too high and the bit under test is cleared; cmpBit = 0 keeps it. After CODE_W comparisons the result appears on lowR0.
- R6: Between R0 trials the heater is off, and the next smpV1a pulses only after sensCode + SPAN/2 <= S0 again.
- R7: During the R4 search, the heater turns on when sensCode + SPAN/4 + HYST < S0 and turns off when sensCode + SPAN/4 > S0 + HYST. This keeps the sensor near the setpoint S0 - SPAN/4.
- R8: Each R4 trial pulses smpV0a with origR0/origR4 applied. It then pulses smpV1a with lowR0 and the R4 trial code applied. After that it raises cmpReq with cmpDiff = 0, only while S0 - SPAN/4 - HYST <= sensCode <= S0 - SPAN/4 + HYST. The R4 result uses the same bit rule as R5 and appears on lowR4.
- R9: When both searches are complete, done is high and r0Code/r4Code equal lowR0/lowR4.
- R10: While done is high, once sensCode + SPAN <= S0 the sequencer takes the current sensor code as the new S0 and the low pair as the new original codes. It drops done and pulses smpV0a with the low pair still applied.
- R11: An abort pulse outside idle returns to idle within one clock. Abort restores the original codes and turns the heater off. No strobe or compare request follows until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration from idle |
| abort | input | 1 | Abandon the sequence and return to idle |
| sensCode | input | SENS_W | Temperature sensor code, rising with temperature |
| cmpBit | input | 1 | Comparator result: 1 means the current trial code is too high |
| origR0 | input | CODE_W | R0 code of the curve in use at start |
| origR4 | input | CODE_W | R4 code of the curve in use at start |
| r0Code | output | CODE_W | R0 DAC code driven to the reference |
| r4Code | output | CODE_W | R4 DAC code driven to the reference |
| heaterOn | output | 1 | Heater enable |
| smpV0a | output | 1 | Sample strobe: original curve, upper point |
| smpV0b | output | 1 | Sample strobe: original curve, lower point |
| smpV1a | output | 1 | Sample strobe: trial curve, first point |
| smpV1b | output | 1 | Sample strobe: trial curve, second point |
| cmpReq | output | 1 | Comparison request; cmpBit is taken in this cycle |
| cmpDiff | output | 1 | 1: compare differences of pairs; 0: compare two samples |
| lowR0 | output | CODE_W | Resulting R0 code for the lower segment |
| lowR4 | output | CODE_W | Resulting R4 code for the lower segment |
| done | output | 1 | Both codes found and applied |

## Verification
The assertions assume cmpBit is valid in the cycle cmpReq is high, as a function of the codes already applied. They also assume the sensor code moves by at most one step per clock, so the regulation band is entered rather than jumped over. The bench meets both conditions: its comparator model is combinational on r0Code/r4Code against a target code, and its thermal model moves sensCode by one count per clock, up while heating and otherwise toward an ambient value the bench sets. Sensor codes stay far from the ends of the range, so the start point minus a full segment is never below zero.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_V0A,
    ST_WLOW,
    ST_LOADT,
    ST_S1A,
    ST_HEAT,
    ST_CMP0,
    ST_SAVE0,
    ST_WDROP,
    ST_HOLD,
    ST_REF,
    ST_NEW,
    ST_CMP4,
    ST_SAVE4,
    ST_ARMED
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capS0;
    logic baseFromIn;
    logic baseFromLow;
    logic applyIn;
    logic applyBase;
    logic applyTrial0;
    logic applyNew;
    logic applyLow;
    logic initR0;
    logic stepR0;
    logic saveR0;
    logic initR4;
    logic stepR4;
    logic saveR4;
  } seqCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lowHalf;
    logic reachS0;
    logic rearm;
    logic belowBand;
    logic aboveBand;
    logic inBand;
    logic lastR0;
    logic lastR4;
  } seqSts_t;

endpackage

// File: rtl/dcal_sar.sv
module dcal_sar #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         step,
  input  logic         cmpHigh,
  output logic [W-1:0] trial,
  output logic         last
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc;
  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      mask <= '0;
    end else if (init) begin
      acc  <= '0;
      mask <= TOP_BIT;
    end else if (step) begin
      if (!cmpHigh) acc <= acc | mask;
      mask <= mask >> 1;
    end
  end

  // once the mask has shifted out, trial equals the final result
  assign trial = acc | mask;
  assign last  = mask[0];

  assert_step_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (mask != '0));

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (trial == TOP_BIT));

endmodule

// File: rtl/dcal_datapath.sv
module dcal_datapath
  import dcal_pkg::*;
#(
  parameter int SENS_W = 10,
  parameter int CODE_W = 6,
  parameter int SPAN   = 64,
  parameter int HYST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic [SENS_W-1:0] sensCode,
  input  logic              cmpBit,
  input  logic [CODE_W-1:0] origR0,
  input  logic [CODE_W-1:0] origR4,
  output seqSts_t           sts,
  output logic [CODE_W-1:0] r0Code,
  output logic [CODE_W-1:0] r4Code,
  output logic [CODE_W-1:0] lowR0,
  output logic [CODE_W-1:0] lowR4
);

  localparam int WIDE = SENS_W + 2;
  localparam logic [WIDE-1:0] FULL_C = WIDE'(SPAN);
  localparam logic [WIDE-1:0] HALF_C = WIDE'(SPAN / 2);
  localparam logic [WIDE-1:0] QTR_C  = WIDE'(SPAN / 4);
  localparam logic [WIDE-1:0] HYS_C  = WIDE'(HYST);

  logic [SENS_W-1:0] s0;
  logic [CODE_W-1:0] base0, base4;
  logic [CODE_W-1:0] trial0, trial4;
  logic              last0, last4;
  logic [WIDE-1:0]   sensW, s0W, setOfs;

  dcal_sar #(.W(CODE_W)) u_sar0 (
    .clk(clk), .rst_n(rst_n), .init(ctl.initR0), .step(ctl.stepR0),
    .cmpHigh(cmpBit), .trial(trial0), .last(last0)
  );

  dcal_sar #(.W(CODE_W)) u_sar4 (
    .clk(clk), .rst_n(rst_n), .init(ctl.initR4), .step(ctl.stepR4),
    .cmpHigh(cmpBit), .trial(trial4), .last(last4)
  );

  // threshold compares done by adding to the sensor side, no underflow
  always_comb begin
    sensW  = WIDE'(sensCode);
    s0W    = WIDE'(s0);
    setOfs = sensW + QTR_C;
    sts.lowHalf   = (sensW + HALF_C) <= s0W;
    sts.reachS0   = sensW >= s0W;
    sts.rearm     = (sensW + FULL_C) <= s0W;
    sts.belowBand = (setOfs + HYS_C) < s0W;
    sts.aboveBand = setOfs > (s0W + HYS_C);
    sts.inBand    = !sts.belowBand && !sts.aboveBand;
    sts.lastR0    = last0;
    sts.lastR4    = last4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0     <= '0;
      base0  <= '0;
      base4  <= '0;
      r0Code <= '0;
      r4Code <= '0;
      lowR0  <= '0;
      lowR4  <= '0;
    end else begin
      if (ctl.capS0) s0 <= sensCode;
      if (ctl.baseFromIn) begin
        base0 <= origR0;
        base4 <= origR4;
      end else if (ctl.baseFromLow) begin
        base0 <= lowR0;
        base4 <= lowR4;
      end
      if (ctl.saveR0) lowR0 <= trial0;
      if (ctl.saveR4) lowR4 <= trial4;
      if (ctl.applyIn) begin
        r0Code <= origR0;
        r4Code <= origR4;
      end else if (ctl.applyBase) begin
        r0Code <= base0;
        r4Code <= base4;
      end else if (ctl.applyTrial0) begin
        r0Code <= trial0;
      end else if (ctl.applyNew) begin
        r0Code <= lowR0;
        r4Code <= trial4;
      end else if (ctl.applyLow) begin
        r0Code <= lowR0;
        r4Code <= trial4;
      end
    end
  end

  // the code under comparison is the one actually driven
  assert_r0_trial_applied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepR0 |-> (r0Code == trial0));

  assert_new_curve_applied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepR4 |-> (r0Code == lowR0 && r4Code == trial4));

endmodule

// File: rtl/dcal_ctrl.sv
module dcal_ctrl
  import dcal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    abort,
  input  seqSts_t sts,
  output seqCtl_t ctl,
  output logic    heaterOn,
  output logic    smpV0a,
  output logic    smpV0b,
  output logic    smpV1a,
  output logic    smpV1b,
  output logic    cmpReq,
  output logic    cmpDiff,
  output logic    done
);

  seqState_t state, nxt;
  logic      heatNext, regHeat;

  // on/off heater with hysteresis around the setpoint
  always_comb begin
    if (sts.belowBand)      regHeat = 1'b1;
    else if (sts.aboveBand) regHeat = 1'b0;
    else                    regHeat = heaterOn;
  end

  always_comb begin
    nxt      = state;
    ctl      = '0;
    heatNext = 1'b0;
    smpV0a   = 1'b0;
    smpV0b   = 1'b0;
    smpV1a   = 1'b0;
    smpV1b   = 1'b0;
    cmpReq   = 1'b0;
    cmpDiff  = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.capS0      = 1'b1;
        ctl.baseFromIn = 1'b1;
        ctl.applyIn    = 1'b1;
        nxt            = ST_V0A;
      end
      ST_V0A: begin
        smpV0a = 1'b1;
        nxt    = ST_WLOW;
      end
      ST_WLOW: if (sts.lowHalf) begin
        smpV0b     = 1'b1;
        ctl.initR0 = 1'b1;
        nxt        = ST_LOADT;
      end
      ST_LOADT: begin
        ctl.applyTrial0 = 1'b1;
        nxt             = ST_S1A;
      end
      ST_S1A: begin
        smpV1a = 1'b1;
        nxt    = ST_HEAT;
      end
      ST_HEAT: begin
        heatNext = !sts.reachS0;
        if (sts.reachS0) begin
          smpV1b = 1'b1;
          nxt    = ST_CMP0;
        end
      end
      ST_CMP0: begin
        cmpReq     = 1'b1;
        cmpDiff    = 1'b1;
        ctl.stepR0 = 1'b1;
        nxt        = sts.lastR0 ? ST_SAVE0 : ST_WDROP;
      end
      ST_SAVE0: begin
        ctl.saveR0 = 1'b1;
        ctl.initR4 = 1'b1;
        nxt        = ST_HOLD;
      end
      ST_WDROP: if (sts.lowHalf) nxt = ST_LOADT;
      ST_HOLD: begin
        heatNext = regHeat;
        if (sts.inBand) begin
          ctl.applyBase = 1'b1;
          nxt           = ST_REF;
        end
      end
      ST_REF: begin
        heatNext     = regHeat;
        smpV0a       = 1'b1;
        ctl.applyNew = 1'b1;
        nxt          = ST_NEW;
      end
      ST_NEW: begin
        heatNext = regHeat;
        smpV1a   = 1'b1;
        nxt      = ST_CMP4;
      end
      ST_CMP4: begin
        heatNext = regHeat;
        if (sts.inBand) begin
          cmpReq     = 1'b1;
          ctl.stepR4 = 1'b1;
          nxt        = sts.lastR4 ? ST_SAVE4 : ST_HOLD;
        end
      end
      ST_SAVE4: begin
        ctl.saveR4   = 1'b1;
        ctl.applyLow = 1'b1;
        nxt          = ST_ARMED;
      end
      ST_ARMED: begin
        done = 1'b1;
        if (sts.rearm) begin
          ctl.capS0       = 1'b1;
          ctl.baseFromLow = 1'b1;
          nxt             = ST_V0A;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (abort && state != ST_IDLE) begin
      ctl           = '0;
      ctl.applyBase = 1'b1;
      heatNext      = 1'b0;
      smpV0a        = 1'b0;
      smpV0b        = 1'b0;
      smpV1a        = 1'b0;
      smpV1b        = 1'b0;
      cmpReq        = 1'b0;
      cmpDiff       = 1'b0;
      done          = 1'b0;
      nxt           = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      heaterOn <= 1'b0;
    end else begin
      state    <= nxt;
      heaterOn <= heatNext;
    end
  end

  // heater must be off whenever the sequencer waits for cooling or is parked
  assert_heater_off_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WLOW || state == ST_WDROP ||
     state == ST_ARMED || state == ST_CMP0) |-> !heaterOn);

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smpV0a, smpV0b, smpV1a, smpV1b, cmpReq}));

endmodule

// File: rtl/dn_cal_sequencer.sv
module dn_cal_sequencer
  import dcal_pkg::*;
#(
  parameter int SENS_W = 10,
  parameter int CODE_W = 6,
  parameter int SPAN   = 64,
  parameter int HYST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [SENS_W-1:0] sensCode,
  input  logic              cmpBit,
  input  logic [CODE_W-1:0] origR0,
  input  logic [CODE_W-1:0] origR4,
  output logic [CODE_W-1:0] r0Code,
  output logic [CODE_W-1:0] r4Code,
  output logic              heaterOn,
  output logic              smpV0a,
  output logic              smpV0b,
  output logic              smpV1a,
  output logic              smpV1b,
  output logic              cmpReq,
  output logic              cmpDiff,
  output logic [CODE_W-1:0] lowR0,
  output logic [CODE_W-1:0] lowR4,
  output logic              done
);

  seqCtl_t ctl;
  seqSts_t sts;

  dcal_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sts(sts),
    .ctl(ctl), .heaterOn(heaterOn), .smpV0a(smpV0a), .smpV0b(smpV0b),
    .smpV1a(smpV1a), .smpV1b(smpV1b), .cmpReq(cmpReq), .cmpDiff(cmpDiff),
    .done(done)
  );

  dcal_datapath #(
    .SENS_W(SENS_W), .CODE_W(CODE_W), .SPAN(SPAN), .HYST(HYST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sensCode(sensCode), .cmpBit(cmpBit),
    .origR0(origR0), .origR4(origR4), .sts(sts), .r0Code(r0Code),
    .r4Code(r4Code), .lowR0(lowR0), .lowR4(lowR4)
  );

  assert_done_applies_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r0Code == lowR0 && r4Code == lowR4));

endmodule

// File: tb/sim_dn_cal_sequencer.sv
module sim_dn_cal_sequencer;

  localparam int SW = 10;
  localparam int CW = 6;
  localparam int S0V = 500;
  localparam int NV = 5;
  // {target R0, target R4}
  localparam logic [11:0] VEC [NV] = '{
    {6'd45, 6'd17}, {6'd0, 6'd63}, {6'd63, 6'd0}, {6'd32, 6'd31}, {6'd1, 6'd62}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, abort = 1'b0, cmpBit;
  logic [SW-1:0] sensCode = 10'(S0V);
  logic [CW-1:0] origR0 = 6'd20, origR4 = 6'd40;
  logic [CW-1:0] r0Code, r4Code, lowR0, lowR4;
  logic heaterOn, smpV0a, smpV0b, smpV1a, smpV1b, cmpReq, cmpDiff, done;

  int ambient = S0V;
  int tgt0 = 0, tgt4 = 0;
  int checks = 0, errors = 0;
  int nV0a, nV0b, nV1a, nV1b, nDiff, nDirect, heatCycles, minS, maxS;
  int lastV0aSens, lastV0aR0, lastV0aR4;
  bit doneSeen;

  always #2 clk = ~clk;

  dn_cal_sequencer u0 (.*);

  // comparator model: 1 when the code under test is above its target
  assign cmpBit = cmpDiff ? (int'(r0Code) > tgt0) : (int'(r4Code) > tgt4);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clrCounts();
    nV0a = 0; nV0b = 0; nV1a = 0; nV1b = 0; nDiff = 0; nDirect = 0;
    heatCycles = 0; minS = 1023; maxS = 0; doneSeen = 0;
  endtask

  // thermal model: one count per clock
  initial forever begin
    @(posedge clk); #1;
    if (heaterOn) sensCode = sensCode + 1'b1;
    else if (int'(sensCode) > ambient) sensCode = sensCode - 1'b1;
    else if (int'(sensCode) < ambient) sensCode = sensCode + 1'b1;
  end

  // output monitor, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      automatic bit r4Phase = (nDiff == CW) && !doneSeen;
      if (done) doneSeen = 1;
      if (heaterOn) heatCycles++;
      if (smpV0a) begin
        nV0a++;
        lastV0aSens = int'(sensCode); lastV0aR0 = int'(r0Code); lastV0aR4 = int'(r4Code);
        if (r4Phase) chk(r0Code == origR0 && r4Code == origR4, "R8 ref codes", int'(r0Code), int'(origR0));
      end
      if (smpV0b) begin
        nV0b++;
        chk(int'(sensCode) + 32 <= S0V, "R3 lower point", int'(sensCode), S0V - 32);
      end
      if (smpV1a) begin
        nV1a++;
        if (nV1a == 1) chk(r0Code == 6'd32, "R4 first trial", int'(r0Code), 32);
        if (!r4Phase) chk(int'(sensCode) + 32 <= S0V, "R6 cooled before trial", int'(sensCode), S0V - 32);
        else chk(int'(r0Code) == tgt0, "R8 new curve R0", int'(r0Code), tgt0);
      end
      if (smpV1b) begin
        nV1b++;
        chk(int'(sensCode) >= S0V, "R4 reheated", int'(sensCode), S0V);
      end
      if (cmpReq && cmpDiff) nDiff++;
      if (cmpReq && !cmpDiff) begin
        nDirect++;
        chk(sensCode >= 482 && sensCode <= 486, "R8 compare in band", int'(sensCode), 484);
      end
      if (r4Phase && nDirect > 0) begin
        if (int'(sensCode) < minS) minS = int'(sensCode);
        if (int'(sensCode) > maxS) maxS = int'(sensCode);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; start = 0; abort = 0; ambient = S0V; sensCode = 10'(S0V);
    repeat (3) @(negedge clk);
    clrCounts();
    rst_n = 1;
  endtask

  task automatic pulse(input bit isAbort);
    @(negedge clk);
    if (isAbort) abort = 1; else start = 1;
    @(negedge clk);
    abort = 0; start = 0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  initial begin
    bit ok;
    int k;
    doReset();
    @(negedge clk);
    chk(r0Code == 0 && r4Code == 0 && lowR0 == 0 && lowR4 == 0, "R1 codes", int'(r0Code), 0);
    chk(!heaterOn && !done && !cmpReq && !smpV0a && !smpV0b && !smpV1a && !smpV1b,
        "R1 controls", int'(heaterOn), 0);

    // table-driven full calibrations
    for (int v = 0; v < NV; v++) begin
      doReset();
      tgt0 = int'(VEC[v][11:6]); tgt4 = int'(VEC[v][5:0]);
      pulse(0);
      chk(r0Code == origR0 && r4Code == origR4, "R2 original applied", int'(r0Code), int'(origR0));
      chk(nV0a == 1, "R2 start sample", nV0a, 1);
      ambient = 400;
      waitDone(ok);
      chk(ok, "R9 done reached", int'(ok), 1);
      chk(int'(lowR0) == tgt0, "R5 R0 result", int'(lowR0), tgt0);
      chk(int'(lowR4) == tgt4, "R8 R4 result", int'(lowR4), tgt4);
      chk(int'(r0Code) == tgt0 && int'(r4Code) == tgt4, "R9 pair applied", int'(r4Code), tgt4);
      chk(nV1b == CW && nDiff == CW, "R4 trial count", nV1b, CW);
      chk(nDirect == CW, "R8 compare count", nDirect, CW);
      chk(nV0b == 1, "R3 single lower sample", nV0b, 1);
      chk(minS >= 478 && maxS <= 490, "R7 regulation window", maxS, 490);
      if (v == NV - 1) begin
        // R10: keep cooling until re-arm
        k = nV0a;
        for (int i = 0; i < 300 && nV0a == k; i++) @(negedge clk);
        chk(nV0a == k + 1, "R10 rearm sample", nV0a, k + 1);
        chk(lastV0aSens + 64 <= S0V, "R10 rearm level", lastV0aSens, S0V - 64);
        chk(lastV0aR0 == tgt0 && lastV0aR4 == tgt4, "R10 low pair kept", lastV0aR0, tgt0);
        chk(!done, "R10 done dropped", int'(done), 0);
      end
    end

    // R3: never cools, so it must sit idle-like until abort
    doReset();
    pulse(0);
    repeat (200) @(negedge clk);
    chk(nV0b == 0 && nV1a == 0, "R3 no lower sample", nV0b, 0);
    chk(heatCycles == 0, "R3 heater idle", heatCycles, 0);
    chk(r0Code == origR0 && r4Code == origR4, "R3 codes held", int'(r4Code), int'(origR4));
    pulse(1);
    chk(r0Code == origR0 && !done && !heaterOn, "R11 abort from wait", int'(r0Code), int'(origR0));

    // R11: abort in the middle of the R0 search
    doReset();
    tgt0 = 10; tgt4 = 10;
    pulse(0);
    ambient = 400;
    for (int i = 0; i < 2000 && nV1b == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(r0Code == 6'd32, "R4 trial held while cooling", int'(r0Code), 32);
    pulse(1);
    chk(r0Code == origR0 && r4Code == origR4, "R11 codes restored", int'(r0Code), int'(origR0));
    chk(!heaterOn, "R11 heater off", int'(heaterOn), 0);
    k = nV0a + nV0b + nV1a + nV1b + nDiff + nDirect;
    heatCycles = 0;
    repeat (60) @(negedge clk);
    chk(nV0a + nV0b + nV1a + nV1b + nDiff + nDirect == k, "R11 quiet after abort",
        nV0a + nV0b + nV1a + nV1b + nDiff + nDirect, k);
    chk(heatCycles == 0, "R11 heater stays off", heatCycles, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule